// File: doc/BRIEF.md
# Power-Up Start Vector Selector

This block decides how a processor begins execution once DC power is reported good. It watches the power-OK bit of a read-only maintenance word. When that bit rises, the block reads a two-bit start option from the same word. The option either loads a fixed start address, loads an address taken from the top nibble of the maintenance word, hands control to the console debugger, or fetches the start PC and PSW from two low-memory words through a simple read port. Each result is reported as a one-cycle strobe.

The same block also handles a halt. When the halt input is seen while no start sequence is running, a single maintenance bit selects between a trap through vector 4 and entry to the debugger. The debugger itself and instruction execution are outside this block.

Top module: `power_start_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, load_o, dbg_o, trap_o and rd_req_o are all low.
- R2: A rising edge of maint_i bit 0 with option field maint_i[2:1] = 2 (mask octal 000006 equal to octal 4) gives load_o high in the next cycle, with pc_o = octal 173000 and psw_o = octal 000340.
- R3: With maint_i[2:1] = 3 (octal 6), the rising edge gives load_o with pc_o = maint_i AND octal 170000 and psw_o = octal 000340. No other maint_i bit reaches pc_o.
- R4: With maint_i[2:1] = 1 (octal 2), the rising edge gives dbg_o for one cycle, with no load_o and no memory read.
- R5: With maint_i[2:1] = 0, the block reads the word at octal 24 and then the word at octal 26. rd_req_o and rd_addr_o stay steady until rd_ack_i. load_o rises in the cycle after the second acknowledge, with pc_o = first word and psw_o = second word, and never before that.
- R6: rd_err_i during either read ends the fetch. dbg_o rises in the next cycle, and no load_o follows.
- R7: Rising edges of maint_i bit 0 while a fetch is in progress are ignored. After the fetch completes, no further read or strobe follows.
- R8: The sequence starts only on a rising edge. A power-OK bit that stays high produces no further strobes.
- R9: halt_i while idle gives trap_o in the next cycle if maint_i bit 3 (octal 000010) is set, and dbg_o if it is clear.
- R10: halt_i during a vector fetch is ignored.
- R11: At most one of load_o, dbg_o and trap_o is high in any cycle, and each is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| maint_i | input | 16 | Maintenance word: bit 0 power OK, bits 2:1 start option, bit 3 halt option, bits 15:12 user start address |
| halt_i | input | 1 | Halt request |
| rd_req_o | output | 1 | Vector read request, held until acknowledged |
| rd_addr_o | output | 16 | Vector read byte address |
| rd_ack_i | input | 1 | Read completed, data valid |
| rd_err_i | input | 1 | Read ended with a bus error |
| rd_data_i | input | 16 | Read data |
| load_o | output | 1 | One-cycle strobe: start at pc_o / psw_o |
| pc_o | output | 16 | Start PC, valid with load_o |
| psw_o | output | 16 | Start PSW, valid with load_o |
| dbg_o | output | 1 | One-cycle strobe: enter console debugger |
| trap_o | output | 1 | One-cycle strobe: trap through vector 4 |

## Verification
The fixed-address option is swept over all sixteen values of the top nibble. This shows that those bits do not leak into the fixed start. The user-address option is swept over the same nibble, with extra middle bits set, so any masking fault shows up in pc_o. The memory-fetch option is tried with several data pairs and acknowledge delays, and then with bus errors on each of the two words. This separates correct ordering and pairing from early loading and from a lost error. Power-OK toggles and halts injected during a pending read, plus halts with the halt bit set and clear, separate the ignore rules from the halt routing.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OPT_VEC   = 2'd0,
    OPT_DBG   = 2'd1,
    OPT_FIXED = 2'd2,
    OPT_USER  = 2'd3
  } popt_e;

  localparam logic [WORD_W-1:0] BOOT_PC_C   = 16'o173000;
  localparam logic [WORD_W-1:0] BOOT_PSW_C  = 16'o000340;
  localparam logic [WORD_W-1:0] USER_MASK_C = 16'o170000;
  localparam logic [WORD_W-1:0] VEC_BASE_C  = 16'o000024;

  function automatic popt_e popt_of(input logic [WORD_W-1:0] m);
    return popt_e'(m[2:1]);
  endfunction

  function automatic logic [WORD_W-1:0] user_pc(input logic [WORD_W-1:0] m,
                                                input logic [WORD_W-1:0] mask);
    return m & mask;
  endfunction

  function automatic logic halt_traps(input logic [WORD_W-1:0] m);
    return m[3];
  endfunction
endpackage

// File: rtl/psel_edge.sv
module psel_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/psel_fetch.sv
module psel_fetch #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] BASE = 16'o24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_ack_i,
  input  logic          rd_err_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] word0_o
);
  localparam int STEP = DW / 8;
  localparam logic [AW-1:0] HI_ADDR = BASE + AW'(STEP);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;
  fst_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      word0_o <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) st_q <= F_LO;
        F_LO: begin
          if (rd_err_i) st_q <= F_IDLE;
          else if (rd_ack_i) begin
            word0_o <= rd_data_i;
            st_q    <= F_HI;
          end
        end
        F_HI: if (rd_ack_i || rd_err_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != F_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = (st_q == F_HI) ? HI_ADDR : BASE;
  assign done_o    = (st_q == F_HI) && rd_ack_i && !rd_err_i;
  assign fail_o    = busy_o && rd_err_i;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && !rd_err_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R5
  second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_addr_o == BASE && rd_ack_i && !rd_err_i) |=> (rd_req_o && rd_addr_o == HI_ADDR));
endmodule

// File: rtl/power_start_sel.sv
module power_start_sel
  import psel_pkg::*;
#(
  parameter logic [WORD_W-1:0] BOOT_PC   = BOOT_PC_C,
  parameter logic [WORD_W-1:0] BOOT_PSW  = BOOT_PSW_C,
  parameter logic [WORD_W-1:0] USER_MASK = USER_MASK_C,
  parameter logic [WORD_W-1:0] VEC_BASE  = VEC_BASE_C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] maint_i,
  input  logic              halt_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              load_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] psw_o,
  output logic              dbg_o,
  output logic              trap_o
);
  logic              rise_w, start_w, fetch_go_w, halt_go_w;
  logic              busy_w, done_w, fail_w;
  logic [WORD_W-1:0] word0_w;
  popt_e             opt_w;

  psel_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(maint_i[0]), .rise_o(rise_w)
  );

  assign opt_w      = popt_of(maint_i);
  assign start_w    = rise_w && !busy_w;
  assign fetch_go_w = start_w && (opt_w == OPT_VEC);
  assign halt_go_w  = halt_i && !busy_w && !start_w;

  psel_fetch #(.AW(WORD_W), .DW(WORD_W), .BASE(VEC_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(fetch_go_w),
    .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i), .rd_data_i(rd_data_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .busy_o(busy_w),
    .done_o(done_w), .fail_o(fail_w), .word0_o(word0_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_o <= 1'b0;
      dbg_o  <= 1'b0;
      trap_o <= 1'b0;
      pc_o   <= '0;
      psw_o  <= '0;
    end else begin
      load_o <= 1'b0;
      dbg_o  <= 1'b0;
      trap_o <= 1'b0;
      if (start_w) begin
        case (opt_w)
          OPT_FIXED: begin
            load_o <= 1'b1;
            pc_o   <= BOOT_PC;
            psw_o  <= BOOT_PSW;
          end
          OPT_USER: begin
            load_o <= 1'b1;
            pc_o   <= user_pc(maint_i, USER_MASK);
            psw_o  <= BOOT_PSW;
          end
          OPT_DBG: dbg_o <= 1'b1;
          default: ;
        endcase
      end else if (done_w) begin
        load_o <= 1'b1;
        pc_o   <= word0_w;
        psw_o  <= rd_data_i;
      end else if (fail_w) begin
        dbg_o <= 1'b1;
      end else if (halt_go_w) begin
        if (halt_traps(maint_i)) trap_o <= 1'b1;
        else                     dbg_o  <= 1'b1;
      end
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, dbg_o, trap_o}));

  // R11
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R2
  fixed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && opt_w == OPT_FIXED) |=> (load_o && pc_o == BOOT_PC && psw_o == BOOT_PSW));

  // R4
  dbg_option_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && opt_w == OPT_DBG) |=> (dbg_o && !rd_req_o));

  // R6
  err_to_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_w |=> (dbg_o && !load_o));

  // R10
  halt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !done_w && !fail_w) |=> (!trap_o && !load_o));
endmodule

// File: tb/tb_power_start_sel.sv
module tb_power_start_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] maint;
  logic        halt;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ack, rd_err;
  logic [15:0] rd_data;
  logic        load, dbg, trap;
  logic [15:0] pc, psw;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  power_start_sel dut (
    .clk(clk), .rst_n(rst_n), .maint_i(maint), .halt_i(halt),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_err_i(rd_err), .rd_data_i(rd_data), .load_o(load), .pc_o(pc),
    .psw_o(psw), .dbg_o(dbg), .trap_o(trap)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {rd_req, load, dbg, trap};
  endfunction

  task automatic power_up(input logic [15:0] val);
    @(negedge clk) maint = val & ~16'd1;
    @(negedge clk);
    @(negedge clk) maint = val | 16'd1;
    @(negedge clk);
  endtask

  task automatic serve(input logic [15:0] addr, input logic [15:0] data,
                       input logic err, input int waits);
    chk(rd_req && rd_addr == addr, "R5 read address", {15'd0, rd_req, rd_addr}, {16'd1, addr});
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(!load && rd_req && rd_addr == addr, "R5 hold while waiting", {load, rd_req}, 2'b01);
    end
    rd_ack = !err; rd_err = err; rd_data = data;
    @(negedge clk);
    rd_ack = 1'b0; rd_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; maint = '0; halt = 1'b0;
    rd_ack = 1'b0; rd_err = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(strobes() == 4'b0, "R1 reset outputs", strobes(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobes() == 4'b0, "R1 after reset", strobes(), 0);

    // R2 fixed start, sweep top nibble
    for (int n = 0; n < 16; n++) begin
      power_up(16'(n * 4096) | 16'o4);
      chk(load && !dbg && pc == 16'o173000 && psw == 16'o340, "R2 fixed start",
          {load, dbg, pc}, {2'b10, 16'o173000});
      @(negedge clk);
      chk(strobes() == 4'b0, "R8 R11 steady high no restart", strobes(), 0);
    end

    // R3 user start, middle bits must be masked
    for (int n = 0; n < 16; n++) begin
      power_up(16'(n * 4096 + 'o1230 + 'o6));
      chk(load && pc == 16'(n * 4096) && psw == 16'o340, "R3 user start",
          {load, pc}, {1'b1, 16'(n * 4096)});
    end

    // R4 debugger option, both halt option values
    for (int h = 0; h < 2; h++) begin
      power_up(16'o2 | 16'(h * 8));
      chk(dbg && !load && !trap && !rd_req, "R4 debugger option", strobes(), 4'b0010);
      @(negedge clk);
      chk(strobes() == 4'b0, "R4 R11 single pulse", strobes(), 0);
    end

    // R5 vector fetch, several data pairs and delays
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w0, w1;
      w0 = 16'(16'o1000 + k * 16'o1234);
      w1 = 16'(16'o340 - k * 16'o40);
      power_up(16'o0);
      serve(16'o24, w0, 1'b0, k % 3);
      chk(!load, "R5 no load after one word", load, 0);
      serve(16'o26, w1, 1'b0, (k + 1) % 3);
      chk(load && pc == w0 && psw == w1, "R5 loaded vector", {load, pc, psw}, {1'b1, w0, w1});
      @(negedge clk);
      chk(strobes() == 4'b0, "R5 idle after load", strobes(), 0);
    end

    // R6 bus error on each word
    for (int e = 0; e < 2; e++) begin
      power_up(16'o0);
      if (e == 0) serve(16'o24, 16'hdead, 1'b1, 1);
      else begin
        serve(16'o24, 16'o1000, 1'b0, 0);
        serve(16'o26, 16'hbeef, 1'b1, 0);
      end
      chk(dbg && !load && !rd_req, "R6 error to debugger", strobes(), 4'b0010);
      @(negedge clk);
      chk(strobes() == 4'b0, "R6 no load later", strobes(), 0);
    end

    // R7 R10 power toggle and halt during fetch
    power_up(16'o10);
    maint = 16'o10;
    @(negedge clk) maint = 16'o11; halt = 1'b1;
    @(negedge clk) halt = 1'b0;
    chk(!trap && !dbg && !load && rd_req && rd_addr == 16'o24, "R7 R10 ignored during fetch",
        strobes(), 4'b1000);
    serve(16'o24, 16'o2000, 1'b0, 0);
    serve(16'o26, 16'o0, 1'b0, 0);
    chk(load && pc == 16'o2000, "R7 fetch completes once", {load, pc}, {1'b1, 16'o2000});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(strobes() == 4'b0, "R7 no second sequence", strobes(), 0);
    end

    // R9 halt routing
    for (int h = 0; h < 2; h++) begin
      @(negedge clk) maint = 16'o1 | 16'(h * 8); halt = 1'b1;
      @(negedge clk) halt = 1'b0;
      if (h == 1) chk(trap && !dbg && !load, "R9 halt traps", strobes(), 4'b0001);
      else        chk(dbg && !trap && !load, "R9 halt to debugger", strobes(), 4'b0010);
      @(negedge clk);
      chk(strobes() == 4'b0, "R9 R11 single pulse", strobes(), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule